// File: doc/BRIEF.md
# Low-Power Gated-Output Scan Chain

This block is a parameterized row of scan storage cells. Each cell keeps one bit and has two outputs. One is a functional output that feeds the logic under test. The other is a dedicated serial output that feeds the next cell. A single shared scan-enable picks the operating mode for the whole row.

In capture mode (scan-enable low), every cell loads its own functional data input on the rising clock edge. The functional outputs then show the stored bits, so the row acts as an ordinary parallel register.

In shift mode (scan-enable high), the cells form a serial path from the chain input, through cell 0 up to the last cell, to the chain output. While scan-enable is high, every functional output is held at 0 by a combinational gate. The logic downstream therefore sees no toggling while patterns are shifted. The serial outputs are not gated, so the chain output always shows the stored bit of the last cell.

The mode is decoded combinationally from scan-enable into two named states: `MODE_CAPTURE` and `MODE_SHIFT`. The transition from capture to shift happens in the same cycle that scan-enable rises. The transition back happens in the same cycle that it falls. No clock edge is involved in either transition.

Top module: `lpscan_top`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, every cell is cleared to 0. After that edge, `scan_out` and every bit of `func_q` read 0, whatever `scan_en`, `scan_in` and `func_d` are.
- R2: When `scan_en` is 1 at a rising edge, cell 0 loads `scan_in` and each cell k (k ≥ 1) loads the value cell k-1 held before the edge. `func_d` has no effect on that edge.
- R3: `scan_out` always equals the stored bit of the last cell (index N-1), in both modes.
- R4: Whenever `scan_en` is 1, all N bits of `func_q` are 0, starting in the same cycle `scan_en` rises and without waiting for a clock edge.
- R5: When `scan_en` is 0, `func_q[k]` equals the stored bit of cell k, and a rising edge loads `func_d[k]` into cell k for every k in parallel. After `scan_en` falls, the stored bits appear on `func_q` in that same cycle.
- R6: A bit applied on `scan_in` at a shift edge appears on `scan_out` after exactly N shift edges. With N = 8, an 8-bit pattern shifted most-significant bit first leaves the chain holding that pattern with bit k in cell k, and is then read back on `scan_out` most-significant bit first.
- R7: A vector captured with `scan_en` at 0 can be unloaded unchanged by shifting. `func_d[N-1]` is on `scan_out` right after the capture edge, and each further shift edge presents the next lower bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; cells update on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset clearing all cells |
| scan_en | input | 1 | 1 = shift mode with functional outputs gated, 0 = capture mode |
| scan_in | input | 1 | Serial input into cell 0 |
| func_d | input | N | Parallel functional data, bit k goes to cell k |
| func_q | output | N | Functional outputs, forced to 0 while scan_en is 1 |
| scan_out | output | 1 | Serial output, stored bit of cell N-1 |

## Verification
The properties assume the following about the inputs:
- The chain holds at least two cells.
- `rst_n` is low from the very first clock edge.
- `scan_en`, `scan_in` and `func_d` are stable around each rising edge, so the mode sampled at the edge is the mode that stored the data.

The bench keeps to these assumptions in three ways:
- It holds reset low from time zero.
- It changes every input only at falling edges.
- It samples outputs one nanosecond after those changes, away from the active edge.

The shifted patterns and the captured vector use alternating and irregular bit mixes. This lets a swapped link or a stuck gate show up on the serial sequence.

// File: rtl/lpscan_pkg.sv
package lpscan_pkg;

    // Operating state of the whole chain, decoded from scan-enable.
    typedef enum logic {
        MODE_CAPTURE = 1'b0,
        MODE_SHIFT   = 1'b1
    } chain_mode_e;

endpackage

// File: rtl/lpscan_mode_dec.sv
module lpscan_mode_dec
    import lpscan_pkg::*;
(
    input  logic        scan_en,
    output chain_mode_e mode
);

    // Purely combinational: the mode changes in the same cycle as scan_en.
    always_comb begin
        unique case (scan_en)
            1'b1:    mode = MODE_SHIFT;
            default: mode = MODE_CAPTURE;
        endcase
    end

endmodule

// File: rtl/lpscan_cell.sv
module lpscan_cell
    import lpscan_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  chain_mode_e mode,
    input  logic        d_in,
    input  logic        ser_in,
    output logic        func_q,
    output logic        ser_q
);

    logic stored;
    logic next_bit;

    // Input selection: serial bit in shift mode, functional bit otherwise.
    always_comb begin
        unique case (mode)
            MODE_SHIFT:   next_bit = ser_in;
            MODE_CAPTURE: next_bit = d_in;
            default:      next_bit = d_in;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stored <= 1'b0;
        end else begin
            stored <= next_bit;
        end
    end

    // Functional output grounded during shift; serial output never gated.
    always_comb begin
        unique case (mode)
            MODE_SHIFT:   func_q = 1'b0;
            MODE_CAPTURE: func_q = stored;
            default:      func_q = stored;
        endcase
        ser_q = stored;
    end

endmodule

// File: rtl/lpscan_top.sv
module lpscan_top
    import lpscan_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         scan_en,
    input  logic         scan_in,
    input  logic [N-1:0] func_d,
    output logic [N-1:0] func_q,
    output logic         scan_out
);

    localparam int LAST = N - 1;

    chain_mode_e  mode;
    logic [N-1:0] cell_q;
    logic [N-1:0] ser_link;

    lpscan_mode_dec u_mode (
        .scan_en (scan_en),
        .mode    (mode)
    );

    // Serial path: scan_in -> cell 0 -> cell 1 -> ... -> cell N-1 -> scan_out
    assign ser_link = {cell_q[N-2:0], scan_in};

    for (genvar k = 0; k < N; k++) begin : g_cell
        lpscan_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .mode   (mode),
            .d_in   (func_d[k]),
            .ser_in (ser_link[k]),
            .func_q (func_q[k]),
            .ser_q  (cell_q[k])
        );
    end

    assign scan_out = cell_q[LAST];

endmodule

// File: rtl/lpscan_checker.sv
module lpscan_checker #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         scan_en,
    input logic         scan_in,
    input logic [N-1:0] func_d,
    input logic [N-1:0] func_q,
    input logic         scan_out,
    input logic [N-1:0] cell_q
);

    // R1: a reset edge leaves both output kinds at zero
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (scan_out == 1'b0 && func_q == '0));

    // R2: a shift edge moves the chain by one and takes scan_in into cell 0
    p_shift_move_r2: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> cell_q == {$past(cell_q[N-2:0]), $past(scan_in)});

    // R3: the serial output tracks the last cell
    p_serial_tap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> scan_out == cell_q[N-1]);

    // R4: functional outputs grounded while shifting
    p_gated_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |-> func_q == '0);

    // R5: a capture edge loads the parallel data seen on func_q next cycle
    p_capture_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |=> (scan_en || func_q == $past(func_d)));

    // R5: in capture mode func_q mirrors the stored bits
    p_capture_view_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |-> func_q == cell_q);

endmodule

bind lpscan_top lpscan_checker #(.N(N)) u_lpscan_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .scan_en  (scan_en),
    .scan_in  (scan_in),
    .func_d   (func_d),
    .func_q   (func_q),
    .scan_out (scan_out),
    .cell_q   (cell_q)
);

// File: tb/tb_lpscan_top.sv
module tb_lpscan_top;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         scan_en = 1'b0;
    logic         scan_in = 1'b0;
    logic [N-1:0] func_d = '0;
    logic [N-1:0] func_q;
    logic         scan_out;

    int checks = 0;
    int errors = 0;
    logic [N-1:0] model = '0;   // expected cell contents, from the requirements

    always #5 clk = ~clk;       // 100 MHz

    lpscan_top #(.N(N)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scan_en  (scan_en),
        .scan_in  (scan_in),
        .func_d   (func_d),
        .func_q   (func_q),
        .scan_out (scan_out)
    );

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: update the model from inputs, pass the rising edge,
    // return at the falling edge, then settle.
    task automatic tick();
        if (!rst_n)       model = '0;
        else if (scan_en) model = {model[N-2:0], scan_in};
        else              model = func_d;
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; scan_en = 1'b1; scan_in = 1'b1; func_d = '1;
        tick(); tick();
        check("R1 scan_out after reset", {{(N-1){1'b0}}, scan_out}, '0);
        scan_en = 1'b0; #1;
        check("R1 func_q after reset", func_q, '0);
        rst_n = 1'b1; func_d = '0;
    endtask

    // Shift a pattern MSB first; return what scan_out showed before each edge.
    task automatic t_shift(input logic [N-1:0] pat, output logic [N-1:0] seen);
        int bad = 0;
        scan_en = 1'b1; func_d = 8'h3C; #1;
        check("R4 func_q zero on scan_en rise", func_q, '0);
        for (int i = 0; i < N; i++) begin
            scan_in = pat[N-1-i];
            func_d = func_d ^ 8'hFF;
            #1;
            seen[N-1-i] = scan_out;
            if (scan_out !== model[N-1]) bad++;
            tick();
            if (func_q !== '0) bad++;
        end
        check("R3/R4 serial tap and gating during shift", N'(bad), '0);
        check("R2 chain contents after shift", model, pat);
    endtask

    task automatic t_patterns();
        logic [N-1:0] seen;
        t_shift(8'h55, seen);
        check("R6 first bit reaches scan_out after N edges", {{(N-1){1'b0}}, scan_out}, {{(N-1){1'b0}}, 1'b0});
        t_shift(8'hAA, seen);
        check("R6 previous pattern read back MSB first", seen, 8'h55);
        check("R6 first bit of 0xAA at scan_out", {{(N-1){1'b0}}, scan_out}, {{(N-1){1'b0}}, 1'b1});
    endtask

    task automatic t_capture_unload(input logic [N-1:0] vec);
        logic [N-1:0] seen;
        scan_en = 1'b0; #1;
        check("R5 stored bits visible once scan_en falls", func_q, 8'hAA);
        func_d = vec;
        tick();
        check("R5 parallel capture", func_q, vec);
        check("R7 top captured bit on scan_out", {{(N-1){1'b0}}, scan_out}, {{(N-1){1'b0}}, vec[N-1]});
        func_d = ~vec;
        t_shift(8'h00, seen);
        check("R7 captured vector unloaded unchanged", seen, vec);
    endtask

    task automatic t_capture_hold();
        scan_en = 1'b0; func_d = 8'h96;
        tick();
        func_d = 8'h0F;
        tick();
        check("R5 second capture overwrites", func_q, 8'h0F);
        check("R3 scan_out in capture mode", {{(N-1){1'b0}}, scan_out}, '0);
        scan_en = 1'b1; #1;
        check("R4 same-cycle gating", func_q, '0);
        scan_en = 1'b0; #1;
        check("R2 no edge, contents kept", func_q, 8'h0F);
        rst_n = 1'b0; scan_en = 1'b1;
        tick();
        rst_n = 1'b1; scan_en = 1'b0; func_d = 8'h00; #1;
        check("R1 mid-run reset clears", func_q, '0);
    endtask

    initial begin
        #1;
        t_reset();
        t_patterns();
        t_capture_unload(8'hC9);
        t_capture_hold();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule